// File: doc/BRIEF.md
# Sector Decoder Host Register Port

This block is the host-facing register port of a CD-ROM sector decoder. The host reaches every register through two operations. The first loads an address register. The second reads or writes a single 8-bit data port. Each data access goes to the register the address register currently selects. After each access the address advances by one and wraps inside a 5-bit window, so the host can sweep a run of registers with repeated data accesses.

The port stores an interrupt-control byte, two control bytes and a 16-bit block pointer. It presents an active-low status byte, and it turns writes to certain addresses into one-cycle command strobes: transfer start, decode start and block reset. The sector buffer datapath and the transfer counter sit outside this block. They report back only through three event inputs, which pull status flags low. The interrupt output is raised while any enabled status flag is low.

Top module: `cdc_host_regs`

## Requirements
- R1: After reset the status byte reads 0xFF, the interrupt-control, control-0 and control-1 bytes and the block pointer are 0, the address register is 0, irq_o is low and no strobe is active.
- R2: A cycle with addr_wr_i high loads the address register with wdata_i[4:0] and discards the upper three bits. Any data read or write requested in that same cycle is ignored.
- R3: Each data read or data write without addr_wr_i advances the address register by one, modulo 32. rdata_o shows the register selected by the current address combinationally. When data_wr_i and data_rd_i are both high, the address advances only once.
- R4: Read map: address 0 is the status byte, 1 is the interrupt-control byte, 2 is control 0, 3 is control 1, 4 is the block pointer low byte and 5 is the block pointer high byte. Every other address reads 0x00.
- R5: Data writes to addresses 1, 2 and 3 store the byte from the next cycle on. dec_en_o follows control-0 bit 7 and wr_req_o follows control-0 bit 2. Writes to address 0 and to unmapped addresses change nothing.
- R6: A write to address 8 with bit 0 set drives the busy flag (status bit 3) to 0 and pulses xfer_start_o for one cycle. With bit 0 clear, the write has no effect. The three strobes are never high together.
- R7: A write to address 4 stages a low byte. A write to address 5 loads blk_ptr_o with {written byte, staged low byte}, pulses decode_start_o for one cycle and sets the decode flag (status bit 5) to 1.
- R8: A write to address 9 sets the transfer-end flag (status bit 6) to 1. A write to address 10 sets the command flag (status bit 7) to 1.
- R9: cmd_event_i clears the command flag, xfer_done_i clears the transfer-end flag and sets the busy flag to 1, and decode_done_i clears the decode flag. An event input overrides an acknowledge, a block reset or a decode start in the same cycle. A transfer start overrides xfer_done_i on the busy flag. Status bits 4, 2, 1 and 0 always read 1.
- R10: irq_o is high exactly when some pair of status bit n and interrupt-control bit n, for n = 7, 6 or 5, has the status bit at 0 and the enable bit at 1.
- R11: A write to address 15 sets all status flags to 1, clears the interrupt-control, control-0 and control-1 bytes, keeps the block pointer and pulses block_reset_o for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_wr_i | input | 1 | Load the address register from wdata_i |
| data_wr_i | input | 1 | Write wdata_i to the selected register |
| data_rd_i | input | 1 | Read access; advances the address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Contents of the selected register |
| cmd_event_i | input | 1 | Command event from the decoder |
| xfer_done_i | input | 1 | Transfer counter reached its end |
| decode_done_i | input | 1 | Sector decode finished |
| irq_o | output | 1 | Combined interrupt request |
| xfer_start_o | output | 1 | One-cycle transfer start strobe |
| decode_start_o | output | 1 | One-cycle decode start strobe |
| block_reset_o | output | 1 | One-cycle block reset strobe |
| blk_ptr_o | output | 16 | Latched block pointer |
| ifctrl_o | output | 8 | Interrupt-control byte (enables, break and wait bits) |
| dec_en_o | output | 1 | Decode enable (control 0 bit 7) |
| wr_req_o | output | 1 | Buffer write request (control 0 bit 2) |
| ctrl1_o | output | 8 | Control 1 byte |

## Verification
The assertions check every cycle that the address register advances or loads as required, that the strobes are mutually exclusive and follow their triggering writes, and that a block reset leaves the interrupt enables clear and the interrupt low. Only the bench's scenarios can show the full read map, the priority between events and acknowledges in the same cycle, the fact that masked or unmapped writes leave the register contents unchanged, and the interrupt combine over random mixes of enables and flags. The bench tracks these against its own register model.

// File: rtl/cdc_host_pkg.sv
package cdc_host_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_STAT     = 5'd0;
  localparam logic [ADDR_W-1:0] A_IFCTRL   = 5'd1;
  localparam logic [ADDR_W-1:0] A_CTRL0    = 5'd2;
  localparam logic [ADDR_W-1:0] A_CTRL1    = 5'd3;
  localparam logic [ADDR_W-1:0] A_PTR_LO   = 5'd4;
  localparam logic [ADDR_W-1:0] A_PTR_HI   = 5'd5;
  localparam logic [ADDR_W-1:0] A_XFER_TRG = 5'd8;
  localparam logic [ADDR_W-1:0] A_XFER_ACK = 5'd9;
  localparam logic [ADDR_W-1:0] A_CMD_ACK  = 5'd10;
  localparam logic [ADDR_W-1:0] A_BLK_RST  = 5'd15;

  // status / interrupt-control bit positions (shared by the combine)
  localparam int F_CMD  = 7;
  localparam int F_XEND = 6;
  localparam int F_DEC  = 5;
  localparam int F_BUSY = 3;
  localparam int N_IRQ  = 3;

  localparam int C0_DEC_EN = 7;
  localparam int C0_WR_REQ = 2;
  localparam int TRG_OUT_EN = 0;

  typedef struct packed {
    logic ifctrl;
    logic ctrl0;
    logic ctrl1;
    logic ptr_lo;
    logic ptr_hi;
    logic xfer_trg;
    logic xfer_ack;
    logic cmd_ack;
    logic blk_rst;
  } wr_sel_t;
endpackage

// File: rtl/cdc_addr_ptr.sv
module cdc_addr_ptr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (step_i) addr_o <= addr_o + ONE;  // wraps in window
  end
endmodule

// File: rtl/cdc_reg_decode.sv
module cdc_reg_decode
  import cdc_host_pkg::*;
#(
  parameter int ADDR_W = cdc_host_pkg::ADDR_W
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_sel_t           sel_o
);
  always_comb begin
    sel_o          = '0;
    sel_o.ifctrl   = wr_en_i && (addr_i == ADDR_W'(A_IFCTRL));
    sel_o.ctrl0    = wr_en_i && (addr_i == ADDR_W'(A_CTRL0));
    sel_o.ctrl1    = wr_en_i && (addr_i == ADDR_W'(A_CTRL1));
    sel_o.ptr_lo   = wr_en_i && (addr_i == ADDR_W'(A_PTR_LO));
    sel_o.ptr_hi   = wr_en_i && (addr_i == ADDR_W'(A_PTR_HI));
    sel_o.xfer_trg = wr_en_i && (addr_i == ADDR_W'(A_XFER_TRG));
    sel_o.xfer_ack = wr_en_i && (addr_i == ADDR_W'(A_XFER_ACK));
    sel_o.cmd_ack  = wr_en_i && (addr_i == ADDR_W'(A_CMD_ACK));
    sel_o.blk_rst  = wr_en_i && (addr_i == ADDR_W'(A_BLK_RST));
  end
endmodule

// File: rtl/cdc_status_flags.sv
module cdc_status_flags
  import cdc_host_pkg::*;
#(
  parameter int DATA_W = cdc_host_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_sel_t           sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cmd_event_i,
  input  logic              xfer_done_i,
  input  logic              decode_done_i,
  input  logic [DATA_W-1:0] ifctrl_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  localparam int IRQ_POS [N_IRQ] = '{F_CMD, F_XEND, F_DEC};

  logic cmd_n_q, xend_n_q, dec_n_q, busy_n_q;
  logic trg_go;

  assign trg_go = sel_i.xfer_trg && wdata_i[TRG_OUT_EN];

  // event inputs take priority over releases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_n_q  <= 1'b1;
      xend_n_q <= 1'b1;
      dec_n_q  <= 1'b1;
      busy_n_q <= 1'b1;
    end else begin
      if (cmd_event_i)                          cmd_n_q <= 1'b0;
      else if (sel_i.cmd_ack || sel_i.blk_rst)  cmd_n_q <= 1'b1;

      if (xfer_done_i)                          xend_n_q <= 1'b0;
      else if (sel_i.xfer_ack || sel_i.blk_rst) xend_n_q <= 1'b1;

      if (decode_done_i)                        dec_n_q <= 1'b0;
      else if (sel_i.ptr_hi || sel_i.blk_rst)   dec_n_q <= 1'b1;

      if (trg_go)                               busy_n_q <= 1'b0;
      else if (xfer_done_i || sel_i.blk_rst)    busy_n_q <= 1'b1;
    end
  end

  always_comb begin
    status_o         = '1;
    status_o[F_CMD]  = cmd_n_q;
    status_o[F_XEND] = xend_n_q;
    status_o[F_DEC]  = dec_n_q;
    status_o[F_BUSY] = busy_n_q;
  end

  logic [N_IRQ-1:0] irq_src;
  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    assign irq_src[g] = !status_o[IRQ_POS[g]] && ifctrl_i[IRQ_POS[g]];
  end
  assign irq_o = |irq_src;
endmodule

// File: rtl/cdc_host_regs.sv
module cdc_host_regs
  import cdc_host_pkg::*;
#(
  parameter int ADDR_W = cdc_host_pkg::ADDR_W,
  parameter int DATA_W = cdc_host_pkg::DATA_W,
  parameter int PTR_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cmd_event_i,
  input  logic              xfer_done_i,
  input  logic              decode_done_i,
  output logic              irq_o,
  output logic              xfer_start_o,
  output logic              decode_start_o,
  output logic              block_reset_o,
  output logic [PTR_W-1:0]  blk_ptr_o,
  output logic [DATA_W-1:0] ifctrl_o,
  output logic              dec_en_o,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] ctrl1_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] ctrl0_q, ptr_lo_stage_q, status_w;
  logic              wr_en, acc_en;
  wr_sel_t           sel;

  assign wr_en  = data_wr_i && !addr_wr_i;
  assign acc_en = (data_wr_i || data_rd_i) && !addr_wr_i;

  cdc_addr_ptr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_wr_i),
    .load_val_i (wdata_i[ADDR_W-1:0]),
    .step_i     (acc_en),
    .addr_o     (addr_q)
  );

  cdc_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i (wr_en),
    .addr_i  (addr_q),
    .sel_o   (sel)
  );

  cdc_status_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_i         (sel),
    .wdata_i       (wdata_i),
    .cmd_event_i   (cmd_event_i),
    .xfer_done_i   (xfer_done_i),
    .decode_done_i (decode_done_i),
    .ifctrl_i      (ifctrl_o),
    .status_o      (status_w),
    .irq_o         (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifctrl_o       <= '0;
      ctrl0_q        <= '0;
      ctrl1_o        <= '0;
      ptr_lo_stage_q <= '0;
      blk_ptr_o      <= '0;
    end else begin
      if (sel.blk_rst) begin
        ifctrl_o <= '0;
        ctrl0_q  <= '0;
        ctrl1_o  <= '0;
      end
      if (sel.ifctrl) ifctrl_o       <= wdata_i;
      if (sel.ctrl0)  ctrl0_q        <= wdata_i;
      if (sel.ctrl1)  ctrl1_o        <= wdata_i;
      if (sel.ptr_lo) ptr_lo_stage_q <= wdata_i;
      if (sel.ptr_hi) blk_ptr_o      <= {wdata_i, ptr_lo_stage_q};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_start_o   <= 1'b0;
      decode_start_o <= 1'b0;
      block_reset_o  <= 1'b0;
    end else begin
      xfer_start_o   <= sel.xfer_trg && wdata_i[TRG_OUT_EN];
      decode_start_o <= sel.ptr_hi;
      block_reset_o  <= sel.blk_rst;
    end
  end

  assign dec_en_o = ctrl0_q[C0_DEC_EN];
  assign wr_req_o = ctrl0_q[C0_WR_REQ];

  always_comb begin
    unique case (addr_q)
      ADDR_W'(A_STAT):   rdata_o = status_w;
      ADDR_W'(A_IFCTRL): rdata_o = ifctrl_o;
      ADDR_W'(A_CTRL0):  rdata_o = ctrl0_q;
      ADDR_W'(A_CTRL1):  rdata_o = ctrl1_o;
      ADDR_W'(A_PTR_LO): rdata_o = blk_ptr_o[DATA_W-1:0];
      ADDR_W'(A_PTR_HI): rdata_o = blk_ptr_o[PTR_W-1:DATA_W];
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cdc_host_regs_chk.sv
module cdc_host_regs_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_wr_i,
  input logic              data_wr_i,
  input logic              data_rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              xfer_done_i,
  input logic              irq_o,
  input logic              xfer_start_o,
  input logic              decode_start_o,
  input logic              block_reset_o,
  input logic [PTR_W-1:0]  blk_ptr_o,
  input logic [DATA_W-1:0] ifctrl_o,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] status_w
);
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_rd_i || data_wr_i) && !addr_wr_i) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  assert_addr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_wr_i |=> addr_q == $past(wdata_i[ADDR_W-1:0]));

  assert_xfer_start_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> ($past(data_wr_i) && $past(wdata_i[0]) && !$past(addr_wr_i)));

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xfer_start_o, decode_start_o, block_reset_o}));

  assert_ptr_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_start_o |-> blk_ptr_o[PTR_W-1:DATA_W] == $past(wdata_i));

  assert_xend_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> !status_w[6]);

  assert_blk_rst_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_reset_o |-> (ifctrl_o == '0) && !irq_o);
endmodule

bind cdc_host_regs cdc_host_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_wr_i      (addr_wr_i),
  .data_wr_i      (data_wr_i),
  .data_rd_i      (data_rd_i),
  .wdata_i        (wdata_i),
  .xfer_done_i    (xfer_done_i),
  .irq_o          (irq_o),
  .xfer_start_o   (xfer_start_o),
  .decode_start_o (decode_start_o),
  .block_reset_o  (block_reset_o),
  .blk_ptr_o      (blk_ptr_o),
  .ifctrl_o       (ifctrl_o),
  .addr_q         (addr_q),
  .status_w       (status_w)
);

// File: tb/sim_cdc_host_regs.sv
module sim_cdc_host_regs;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic addr_wr, data_wr, data_rd, ce, xd, dd;
  logic [7:0] wdata, rdata, ifctrl, ctrl1;
  logic irq, xs, ds, br, dec_en, wr_req;
  logic [15:0] ptr;

  always #4 clk = ~clk;

  cdc_host_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_wr_i(addr_wr), .data_wr_i(data_wr),
    .data_rd_i(data_rd), .wdata_i(wdata), .rdata_o(rdata), .cmd_event_i(ce),
    .xfer_done_i(xd), .decode_done_i(dd), .irq_o(irq), .xfer_start_o(xs),
    .decode_start_o(ds), .block_reset_o(br), .blk_ptr_o(ptr), .ifctrl_o(ifctrl),
    .dec_en_o(dec_en), .wr_req_o(wr_req), .ctrl1_o(ctrl1)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [4:0]  m_addr;
  logic [7:0]  m_ifc, m_c0, m_c1, m_plo;
  logic [15:0] m_ptr;
  logic        m_cmd, m_xe, m_dec, m_busy, m_xs, m_ds, m_br;

  function automatic logic [7:0] m_status();
    return {m_cmd, m_xe, m_dec, 1'b1, m_busy, 3'b111};
  endfunction

  function automatic logic [7:0] m_read(input logic [4:0] a);
    case (a)
      5'd0: return m_status();
      5'd1: return m_ifc;
      5'd2: return m_c0;
      5'd3: return m_c1;
      5'd4: return m_ptr[7:0];
      5'd5: return m_ptr[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic m_irq();
    return (!m_cmd && m_ifc[7]) || (!m_xe && m_ifc[6]) || (!m_dec && m_ifc[5]);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R4 rdata", 16'(rdata), 16'(m_read(m_addr)));
    chk("R10 irq", 16'(irq), 16'(m_irq()));
    chk("R6 xfer_start", 16'(xs), 16'(m_xs));
    chk("R7 decode_start", 16'(ds), 16'(m_ds));
    chk("R11 block_reset", 16'(br), 16'(m_br));
    chk("R7 ptr", ptr, m_ptr);
    chk("R5 ctrl", {ifctrl, ctrl1}, {m_ifc, m_c1});
    chk("R5 c0 bits", {14'd0, dec_en, wr_req}, {14'd0, m_c0[7], m_c0[2]});
  endtask

  task automatic step(input logic aw, input logic dw, input logic dr, input logic [7:0] wd,
                      input logic e_c, input logic e_x, input logic e_d);
    logic wr, acc, trg;
    logic [4:0] a;
    @(negedge clk);
    addr_wr = aw; data_wr = dw; data_rd = dr; wdata = wd; ce = e_c; xd = e_x; dd = e_d;
    @(posedge clk);
    wr = dw && !aw; acc = (dw || dr) && !aw; a = m_addr;
    trg = wr && a == 5'd8 && wd[0];
    m_xs = trg; m_ds = wr && a == 5'd5; m_br = wr && a == 5'd15;
    if (aw) m_addr = wd[4:0];
    else if (acc) m_addr = m_addr + 5'd1;
    if (e_c) m_cmd = 0; else if (wr && (a == 5'd10 || a == 5'd15)) m_cmd = 1;
    if (e_x) m_xe = 0;  else if (wr && (a == 5'd9 || a == 5'd15)) m_xe = 1;
    if (e_d) m_dec = 0; else if (wr && (a == 5'd5 || a == 5'd15)) m_dec = 1;
    if (trg) m_busy = 0; else if (e_x || (wr && a == 5'd15)) m_busy = 1;
    if (wr) begin
      case (a)
        5'd1: m_ifc = wd;
        5'd2: m_c0 = wd;
        5'd3: m_c1 = wd;
        5'd4: m_plo = wd;
        5'd5: m_ptr = {wd, m_plo};
        5'd15: begin m_ifc = 0; m_c0 = 0; m_c1 = 0; end
        default: ;
      endcase
    end
    #2;
    check_all();
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    step(1, 0, 0, {3'b0, a}, 0, 0, 0);
    step(0, 1, 0, d, 0, 0, 0);
  endtask

  function automatic logic [4:0] pick(input int r);
    case (r)
      0: return 5'd0;  1: return 5'd1;  2: return 5'd2;  3: return 5'd3;
      4: return 5'd4;  5: return 5'd5;  6: return 5'd8;  7: return 5'd9;
      8: return 5'd10; 9: return 5'd15; 10: return 5'd1; 11: return 5'd8;
      default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    addr_wr = 0; data_wr = 0; data_rd = 0; wdata = 0; ce = 0; xd = 0; dd = 0;
    m_addr = 0; m_ifc = 0; m_c0 = 0; m_c1 = 0; m_plo = 0; m_ptr = 0;
    m_cmd = 1; m_xe = 1; m_dec = 1; m_busy = 1; m_xs = 0; m_ds = 0; m_br = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", 16'(rdata), 16'hFF);
    chk("R1 irq/strobes", {12'd0, irq, xs, ds, br}, 16'd0);
    chk("R1 ptr", ptr, 16'd0);
    chk("R1 ctrl", {ifctrl, ctrl1}, 16'd0);

    // R2 masked load, and data access ignored while loading
    wr_reg(5'd3, 8'hA5);
    step(1, 0, 0, 8'hE3, 0, 0, 0);
    chk("R2 masked load", 16'(rdata), 16'hA5);
    step(1, 1, 0, 8'h23, 0, 0, 0);
    chk("R2 write ignored on load", 16'(ctrl1), 16'hA5);

    // R3 wrap from 31 to 0
    step(1, 0, 0, 8'h1F, 0, 0, 0);
    step(0, 0, 1, 8'h00, 0, 0, 0);
    chk("R3 wrap to status", 16'(rdata), 16'(m_status()));
    step(0, 1, 1, 8'h00, 0, 0, 0);
    chk("R3 rd+wr single step", 16'(rdata), 16'(m_ifc));

    // R6 trigger without output-enable has no effect
    wr_reg(5'd8, 8'hFE);
    chk("R6 no strobe", 16'(xs), 16'd0);
    step(1, 0, 0, 8'h00, 0, 0, 0);
    chk("R6 busy kept", 16'(rdata[3]), 16'd1);
    wr_reg(5'd8, 8'h01);
    chk("R6 strobe", 16'(xs), 16'd1);

    // R7 pointer latch
    wr_reg(5'd4, 8'h34);
    step(0, 1, 0, 8'h12, 0, 0, 0);
    chk("R7 ptr latch", ptr, 16'h1234);

    // R9 / R8 transfer-end flag and irq
    wr_reg(5'd1, 8'hE0);
    step(0, 0, 0, 8'h00, 0, 1, 0);
    chk("R9 irq on xfer end", 16'(irq), 16'd1);
    step(1, 0, 0, 8'h09, 0, 0, 0);
    step(0, 1, 0, 8'h00, 0, 1, 0);
    chk("R9 event beats ack", 16'(irq), 16'd1);
    wr_reg(5'd9, 8'h00);
    chk("R8 ack clears irq", 16'(irq), 16'd0);
    step(0, 0, 0, 8'h00, 1, 0, 0);
    wr_reg(5'd10, 8'h00);
    chk("R8 cmd ack", 16'(irq), 16'd0);

    // R11 block reset
    wr_reg(5'd2, 8'h84);
    step(0, 0, 0, 8'h00, 1, 1, 1);
    wr_reg(5'd15, 8'h00);
    chk("R11 strobe", 16'(br), 16'd1);
    step(1, 0, 0, 8'h00, 0, 0, 0);
    chk("R11 status", 16'(rdata), 16'hFF);
    chk("R11 ptr kept", ptr, 16'h1234);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic w;
      w = $urandom_range(0, 1);
      step(1, 0, 0, {3'($urandom), pick($urandom_range(0, 15))}, 0, 0, 0);
      step(0, w, !w || ($urandom_range(0, 7) == 0), 8'($urandom),
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule